// File: doc/BRIEF.md
# Exception Priority Selector

This block gathers the exception requests raised while one instruction executes and decides, once that instruction completes, which single exception the core takes. Five sources can raise a request: software interrupt, fast interrupt, normal interrupt, undefined instruction and reset. Each is a one-cycle set pulse. An extra pair of inputs reports an instruction that no decoder recognised, and the block routes it to either the software interrupt or the undefined instruction source. Set pulses stick in a pending register until the end-of-instruction strobe arrives.

On that strobe the pending requests, plus any set pulses in the same cycle, pass through a fixed priority chain. Two mask inputs gate the two interrupt sources. The winner is registered as a one-cycle take strobe, together with an exception code and a vector address. The whole pending register is then emptied. Requests that lost or were masked are dropped, not kept. The vector base is a parameter, so the vector table can be placed anywhere on a 32-byte boundary.

Top module: `exc_priority_sel`

## Requirements
- R1: After reset `take_valid` is 0, `take_kind` is 0, `take_vector` is 0 and no request is pending.
- R2: Set pulses accumulate across cycles. Nothing is taken in any cycle that does not follow an `instr_done` cycle.
- R3: When several requests are eligible, the order from highest to lowest is software interrupt, fast interrupt, normal interrupt, undefined instruction, reset.
- R4: A fast interrupt is taken only if `fiq_mask` is 0 in the `instr_done` cycle.
- R5: A normal interrupt is taken only if `irq_mask` is 0 in the `instr_done` cycle.
- R6: At most one exception is taken per evaluation. `take_valid` is high only in the cycle right after an `instr_done` cycle.
- R7: Every evaluation empties the pending register, whether or not anything was taken. Masked and losing requests are discarded.
- R8: A pulse on `unk_op` raises a software interrupt request when `unk_is_swi` is 1, and an undefined instruction request otherwise.
- R9: `take_kind` codes are: none 0, software interrupt 1, fast interrupt 2, normal interrupt 3, undefined 4, reset 5. `take_vector` is VEC_BASE plus an offset: reset 0x00, undefined 0x04, software interrupt 0x08, normal interrupt 0x18, fast interrupt 0x1C. When `take_valid` is 0, both `take_kind` and `take_vector` are 0.
- R10: A set pulse in the same cycle as `instr_done` takes part in that evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swi_req | input | 1 | Software interrupt set pulse |
| fiq_req | input | 1 | Fast interrupt set pulse |
| irq_req | input | 1 | Normal interrupt set pulse |
| undef_req | input | 1 | Undefined instruction set pulse |
| reset_req | input | 1 | Reset exception set pulse |
| unk_op | input | 1 | Unrecognised instruction pulse |
| unk_is_swi | input | 1 | The unrecognised instruction was a software interrupt encoding |
| instr_done | input | 1 | End-of-instruction strobe that triggers evaluation |
| fiq_mask | input | 1 | Blocks fast interrupts when 1 |
| irq_mask | input | 1 | Blocks normal interrupts when 1 |
| take_valid | output | 1 | One-cycle take strobe |
| take_kind | output | 3 | Code of the exception taken |
| take_vector | output | VEC_W | Vector address of the exception taken |

## Verification
The properties assume that the inputs are clean 0/1 values that settle before each rising edge. They also assume that the masks need only be valid in the `instr_done` cycle, because the mask checks compare against the masks one cycle back. The stimulus changes every input only on the falling edge and holds the inputs low during reset. It mixes random pulses, random masks and `instr_done` at about one cycle in four, including back-to-back strobes, so the discard property that spans two consecutive evaluations is exercised.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

   // Priority slots: a lower slot number wins.
   localparam int SLOT_SWI   = 0;
   localparam int SLOT_FIQ   = 1;
   localparam int SLOT_IRQ   = 2;
   localparam int SLOT_UNDEF = 3;
   localparam int SLOT_RESET = 4;
   localparam int NUM_SLOTS  = 5;

   localparam int KIND_W   = 3;
   localparam int OFFSET_W = 5;

   typedef enum logic [KIND_W-1:0] {
      KIND_NONE  = 3'd0,
      KIND_SWI   = 3'd1,
      KIND_FIQ   = 3'd2,
      KIND_IRQ   = 3'd3,
      KIND_UNDEF = 3'd4,
      KIND_RESET = 3'd5
   } exc_kind_e;

   function automatic logic [KIND_W-1:0] slot_kind(input int slot);
      case (slot)
         SLOT_SWI:   return KIND_SWI;
         SLOT_FIQ:   return KIND_FIQ;
         SLOT_IRQ:   return KIND_IRQ;
         SLOT_UNDEF: return KIND_UNDEF;
         SLOT_RESET: return KIND_RESET;
         default:    return KIND_NONE;
      endcase
   endfunction

   function automatic logic [OFFSET_W-1:0] slot_offset(input int slot);
      case (slot)
         SLOT_SWI:   return 5'h08;
         SLOT_FIQ:   return 5'h1C;
         SLOT_IRQ:   return 5'h18;
         SLOT_UNDEF: return 5'h04;
         default:    return 5'h00;
      endcase
   endfunction

endpackage

// File: rtl/exc_req_collect.sv
module exc_req_collect #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         evaluate,
   output logic [N-1:0] merged
);

   logic [N-1:0] pend_q;

   for (genvar g = 0; g < N; g++) begin : g_bit
      assign merged[g] = pend_q[g] | set_vec[g];

      always_ff @(posedge clk) begin
         if (!rst_n)        pend_q[g] <= 1'b0;
         else if (evaluate) pend_q[g] <= 1'b0;
         else               pend_q[g] <= merged[g];
      end
   end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   input  logic [N-1:0] allow,
   output logic [N-1:0] grant,
   output logic         any
);

   logic [N-1:0] elig;
   assign elig = req & allow;
   assign any  = |elig;

   for (genvar g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_top
         assign grant[g] = elig[g];
      end else begin : g_rest
         assign grant[g] = elig[g] & ~(|elig[g-1:0]);
      end
   end

endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
   import exc_sel_pkg::*;
#(
   parameter int              N        = NUM_SLOTS,
   parameter int              VEC_W    = 32,
   parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
   input  logic [N-1:0]      grant,
   output logic [KIND_W-1:0] kind,
   output logic [VEC_W-1:0]  vector
);

   logic [OFFSET_W-1:0] off;

   always_comb begin
      kind = '0;
      off  = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) begin
            kind = kind | slot_kind(i);
            off  = off  | slot_offset(i);
         end
      end
   end

   if (VEC_W == OFFSET_W) begin : g_narrow
      assign vector = (|grant) ? (VEC_BASE | off) : '0;
   end else begin : g_wide
      assign vector = (|grant) ? (VEC_BASE | {{(VEC_W-OFFSET_W){1'b0}}, off}) : '0;
   end

endmodule

// File: rtl/exc_priority_sel.sv
module exc_priority_sel
   import exc_sel_pkg::*;
#(
   parameter int              VEC_W    = 32,
   parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swi_req,
   input  logic              fiq_req,
   input  logic              irq_req,
   input  logic              undef_req,
   input  logic              reset_req,
   input  logic              unk_op,
   input  logic              unk_is_swi,
   input  logic              instr_done,
   input  logic              fiq_mask,
   input  logic              irq_mask,
   output logic              take_valid,
   output logic [2:0]        take_kind,
   output logic [VEC_W-1:0]  take_vector
);

   localparam int N = NUM_SLOTS;

   if (VEC_W < OFFSET_W) begin : g_bad_width
      $error("exc_priority_sel: VEC_W must be at least 5");
   end
   if ((VEC_BASE % 32) != 0) begin : g_bad_base
      $error("exc_priority_sel: VEC_BASE must sit on a 32-byte boundary");
   end

   logic [N-1:0] set_vec;
   logic [N-1:0] merged;
   logic [N-1:0] allow;
   logic [N-1:0] grant;
   logic         any;
   logic [KIND_W-1:0] kind_c;
   logic [VEC_W-1:0]  vec_c;

   always_comb begin
      set_vec             = '0;
      set_vec[SLOT_SWI]   = swi_req   | (unk_op &  unk_is_swi);
      set_vec[SLOT_FIQ]   = fiq_req;
      set_vec[SLOT_IRQ]   = irq_req;
      set_vec[SLOT_UNDEF] = undef_req | (unk_op & ~unk_is_swi);
      set_vec[SLOT_RESET] = reset_req;
      allow               = '1;
      allow[SLOT_FIQ]     = ~fiq_mask;
      allow[SLOT_IRQ]     = ~irq_mask;
   end

   exc_req_collect #(.N(N)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .evaluate (instr_done),
      .merged   (merged)
   );

   exc_prio_pick #(.N(N)) u_pick (
      .req   (merged),
      .allow (allow),
      .grant (grant),
      .any   (any)
   );

   exc_vec_map #(.N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_map (
      .grant  (grant),
      .kind   (kind_c),
      .vector (vec_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_valid  <= 1'b0;
         take_kind   <= KIND_NONE;
         take_vector <= '0;
      end else if (instr_done && any) begin
         take_valid  <= 1'b1;
         take_kind   <= kind_c;
         take_vector <= vec_c;
      end else begin
         take_valid  <= 1'b0;
         take_kind   <= KIND_NONE;
         take_vector <= '0;
      end
   end

endmodule

// File: rtl/exc_priority_sel_chk.sv
module exc_priority_sel_chk #(
   parameter int              VEC_W    = 32,
   parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             swi_req,
   input logic             fiq_req,
   input logic             irq_req,
   input logic             undef_req,
   input logic             reset_req,
   input logic             unk_op,
   input logic             instr_done,
   input logic             fiq_mask,
   input logic             irq_mask,
   input logic             take_valid,
   input logic [2:0]       take_kind,
   input logic [VEC_W-1:0] take_vector
);

   logic any_set;
   assign any_set = swi_req | fiq_req | irq_req | undef_req | reset_req | unk_op;

   AST_TAKE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      take_valid |-> $past(instr_done)); // R6

   AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      take_valid |-> (take_kind >= 3'd1 && take_kind <= 3'd5)); // R6

   AST_FIQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && take_kind == 3'd2) |-> !$past(fiq_mask)); // R4

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && take_kind == 3'd3) |-> !$past(irq_mask)); // R5

   AST_SWI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(instr_done) && $past(swi_req)) |-> (take_valid && take_kind == 3'd1)); // R3

   AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !take_valid |-> (take_kind == 3'd0 && take_vector == '0)); // R9

   AST_RESET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && take_kind == 3'd5) |-> take_vector == VEC_BASE); // R9

   AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done && !any_set && $past(instr_done)) |=> !take_valid); // R7

endmodule

bind exc_priority_sel exc_priority_sel_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .swi_req     (swi_req),
   .fiq_req     (fiq_req),
   .irq_req     (irq_req),
   .undef_req   (undef_req),
   .reset_req   (reset_req),
   .unk_op      (unk_op),
   .instr_done  (instr_done),
   .fiq_mask    (fiq_mask),
   .irq_mask    (irq_mask),
   .take_valid  (take_valid),
   .take_kind   (take_kind),
   .take_vector (take_vector)
);

// File: tb/exc_priority_sel_tb.sv
`timescale 1ns/1ps
module exc_priority_sel_tb;

   localparam int VEC_W = 32;
   localparam logic [VEC_W-1:0] BASE = 32'hFFFF_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic swi_req = 0, fiq_req = 0, irq_req = 0, undef_req = 0, reset_req = 0;
   logic unk_op = 0, unk_is_swi = 0, instr_done = 0, fiq_mask = 0, irq_mask = 0;
   logic             take_valid;
   logic [2:0]       take_kind;
   logic [VEC_W-1:0] take_vector;

   always #2 clk = ~clk;

   exc_priority_sel #(.VEC_W(VEC_W), .VEC_BASE(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .swi_req(swi_req), .fiq_req(fiq_req), .irq_req(irq_req),
      .undef_req(undef_req), .reset_req(reset_req),
      .unk_op(unk_op), .unk_is_swi(unk_is_swi), .instr_done(instr_done),
      .fiq_mask(fiq_mask), .irq_mask(irq_mask),
      .take_valid(take_valid), .take_kind(take_kind), .take_vector(take_vector)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // bench model: bit0 swi, bit1 fiq, bit2 irq, bit3 undef, bit4 reset
   logic [4:0]       m_pend = '0;
   logic             e_valid = 0;
   logic [2:0]       e_kind = 0;
   logic [VEC_W-1:0] e_vec = '0;
   string            e_tag = "R1";

   function automatic logic [2:0] pick(input logic [4:0] r, input logic fm, input logic im);
      if (r[0])        return 3'd1;
      if (r[1] && !fm) return 3'd2;
      if (r[2] && !im) return 3'd3;
      if (r[3])        return 3'd4;
      if (r[4])        return 3'd5;
      return 3'd0;
   endfunction

   function automatic logic [VEC_W-1:0] vec_of(input logic [2:0] k);
      case (k)
         3'd1: return BASE + 32'h08;
         3'd2: return BASE + 32'h1C;
         3'd3: return BASE + 32'h18;
         3'd4: return BASE + 32'h04;
         3'd5: return BASE;
         default: return '0;
      endcase
   endfunction

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_out();
      cmp(e_tag, "take_valid", {31'd0, take_valid}, {31'd0, e_valid});
      cmp(e_tag, "take_kind", {29'd0, take_kind}, {29'd0, e_kind});
      cmp("R9", "take_vector", take_vector, e_vec);
   endtask

   task automatic step(input logic s, input logic f, input logic i, input logic u,
                       input logic r, input logic uk, input logic uks, input logic d,
                       input logic fm, input logic im, input string tag);
      logic [4:0] sets;
      logic [4:0] mrg;
      logic [2:0] k;
      @(negedge clk);
      check_out();
      swi_req = s; fiq_req = f; irq_req = i; undef_req = u; reset_req = r;
      unk_op = uk; unk_is_swi = uks; instr_done = d; fiq_mask = fm; irq_mask = im;
      sets = {r, u | (uk & ~uks), i, f, s | (uk & uks)};
      mrg  = m_pend | sets;
      if (d) begin
         k = pick(mrg, fm, im);
         m_pend = '0;
      end else begin
         k = 3'd0;
         m_pend = mrg;
      end
      e_valid = (k != 3'd0);
      e_kind  = k;
      e_vec   = vec_of(k);
      if (tag != "") e_tag = tag;
      else if (k == 3'd2) e_tag = "R4";
      else if (k == 3'd3) e_tag = "R5";
      else if (k != 3'd0) e_tag = "R3";
      else if (d) e_tag = "R7";
      else e_tag = "R2";
   endtask

   task automatic idle(input string tag);
      step(0,0,0,0,0,0,0,0,0,0, tag);
   endtask

   initial begin
      void'($urandom(32'd5150));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, and an empty evaluation takes nothing
      idle("R1");
      step(0,0,0,0,0,0,0,1,0,0, "R1");
      idle("");
      // R3/R10: all sources raised in the done cycle, software interrupt wins
      step(1,1,1,1,1,0,0,1,0,0, "R3");
      // R4: fast interrupt masked, normal interrupt wins
      step(0,1,1,1,1,0,0,1,1,0, "R4");
      // R5: both interrupts masked, undefined wins
      step(0,1,1,1,0,0,0,1,1,1, "R5");
      // R2: accumulation over cycles, no output before done
      step(0,1,0,0,0,0,0,0,0,0, "R2");
      step(0,0,1,0,0,0,0,0,0,0, "R2");
      idle("R2");
      step(0,0,0,0,0,0,0,1,0,0, "R2");
      // R7: masked-only request is discarded
      step(0,0,1,0,0,0,0,1,0,1, "R7");
      step(0,0,0,0,0,0,0,1,0,0, "R7");
      idle("R7");
      // R8: unknown instruction routing
      step(0,0,0,0,0,1,1,1,0,0, "R8");
      step(0,0,0,0,0,1,0,1,0,0, "R8");
      // R9: reset vector lands on the base
      step(0,0,0,0,1,0,0,1,0,0, "R9");
      // R10: set in same cycle as done
      step(0,0,1,0,0,0,0,1,0,0, "R10");
      // R6: strobe lasts a single cycle
      idle("R6");
      idle("R6");
      // random mix
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
              ($urandom % 8) == 0, ($urandom % 12) == 0, ($urandom % 10) == 0,
              $urandom % 2, ($urandom % 4) == 0, ($urandom % 3) == 0,
              ($urandom % 3) == 0, "");
      end
      idle("");
      idle("");
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule